// File: doc/BRIEF.md
# Event Counter Bank

This block holds a set of programmable event counters of the kind found beside a processor core for performance monitoring. It has four general counters and three fixed counters by default, and the counter width is a parameter. Every cycle the core offers a small increment count on each of its event lanes, together with a flag that says whether the core is running in user or in supervisor mode. A general counter picks one lane through its selection register. It can add the raw count, or it can apply a threshold, an inverted threshold or a rising-edge rule. Each fixed counter is hard-wired to its own lane and has a 4-bit control field.

A global enable bitmap gates all counters. A counter advances only when its own enable and its global bit are both set, and when its privilege filter matches the current mode. When a counter wraps past all ones, it sets a sticky bit in a global overflow status word. Software clears that bit by writing a mask to a separate clear address. The interrupt request is a level. It is high while any status bit is set whose counter has its interrupt enable set. Software reaches every register through a simple single-cycle port, with combinational reads and synchronous writes. It may load a counter while that counter runs, so a preload of minus N overflows after N events.

Top module: `evt_counter_bank`

## Requirements
- R1: After reset every counter, selection register, the fixed control word, the global enable word and the status word read as zero, and the interrupt request is low.
- R2: A general counter g adds the count of event lane sel[2:0] each cycle when its enable (sel bit 22) is set, global enable bit g is set, and the privilege filter matches: sel bit 16 admits user mode (privUser=1) and sel bit 17 admits supervisor mode (privUser=0).
- R3: A counter whose global enable bit or local enable is clear keeps its value.
- R4: Fixed counter f adds fixCount[f] when global enable bit 32+f is set and its control field at bits 4f+3:4f admits the mode: field bit 0 for supervisor mode, field bit 1 for user mode.
- R5: When the threshold field sel[31:24] is nonzero, a general counter adds one in each cycle where the lane count is at least the threshold. With the invert bit sel[23] set, it adds one in each cycle where the lane count is below the threshold.
- R6: With a nonzero threshold and the edge bit sel[18] set, a general counter adds one only in a cycle where the threshold condition is true and was false in the previous cycle.
- R7: A counter that wraps past all ones continues modulo 2^CNT_W and sets its status bit, at position g for general counters and 32+f for fixed counters, in the following cycle.
- R8: Status bits are sticky. A write to the clear address (31) clears the bits set in the data; an overflow in the same cycle wins; writes to the status address (30) have no effect.
- R9: irq is high exactly while some status bit is set whose counter has its interrupt enable set (sel bit 20 for general counters, field bit 3 for fixed counters).
- R10: A write to a counter, even while it counts, replaces its value from the next cycle; that cycle's increment is dropped and the counter cannot overflow in that cycle; counting then continues from the written value.
- R11: Register map: counters at addresses 0..6 (general first, zero-extended), selection registers at 16..19, fixed control at 28, global enable at 29, status at 30. Address 31 and unused addresses read as zero. Reads are combinational.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| privUser | input | 1 | 1 when the core runs in user mode, 0 in supervisor mode |
| evtCount | input | NUM_EVT x INC_W | Per-cycle increment count of each event lane |
| fixCount | input | NUM_FIX x INC_W | Per-cycle increment count of each fixed lane |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Register address |
| regWrData | input | 64 | Register write data |
| regRdData | output | 64 | Combinational read data for regAddr |
| irq | output | 1 | Level interrupt request |

## Verification
The hardest conditions to reach from the ports are counter overflow and its interaction with software writes in the same cycle. A 48-bit counter never wraps through counting alone in a short run. The stimulus therefore loads counters with values a few counts below all ones, both in directed sequences and in random writes biased to that region. Random clear-mask writes then land in the same cycles as fresh overflows, and counter writes land in cycles where the lane is active. Edge and inverted-threshold modes are reached by randomising the selection fields while the lane counts change every cycle. A bench model tracks the previous-cycle condition to predict each increment.

// File: rtl/ecb_pkg.sv
package ecb_pkg;
  localparam int ADDR_W = 5;
  localparam int REG_W = 64;
  localparam int MAX_CNT = 16;
  localparam int GLOBAL_FIX_BASE = 32;

  localparam logic [ADDR_W-1:0] ADDR_SEL_BASE = 5'd16;
  localparam logic [ADDR_W-1:0] ADDR_FIXCTL = 5'd28;
  localparam logic [ADDR_W-1:0] ADDR_GEN = 5'd29;
  localparam logic [ADDR_W-1:0] ADDR_STAT = 5'd30;
  localparam logic [ADDR_W-1:0] ADDR_CLR = 5'd31;

  // selection register field positions
  localparam int SEL_USR = 16;
  localparam int SEL_OS = 17;
  localparam int SEL_EDGE = 18;
  localparam int SEL_INT = 20;
  localparam int SEL_EN = 22;
  localparam int SEL_INV = 23;
  localparam int SEL_THR_LSB = 24;

  // fixed control field positions inside each 4-bit field
  localparam int FIX_OS = 0;
  localparam int FIX_USR = 1;
  localparam int FIX_INT = 3;

  typedef struct packed {
    logic [MAX_CNT-1:0] cntWr;
    logic [REG_W-1:0] wrData;
  } ecbStrobe_t;
endpackage

// File: rtl/ecb_datapath.sv
module ecb_datapath
  import ecb_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FIX = 3,
  parameter int NUM_EVT = 8,
  parameter int INC_W = 4,
  parameter int CNT_W = 48
) (
  input  logic clk,
  input  logic rstN,
  input  ecbStrobe_t strobe,
  input  logic privUser,
  input  logic [NUM_EVT-1:0][INC_W-1:0] evtCount,
  input  logic [NUM_FIX-1:0][INC_W-1:0] fixCount,
  input  logic [NUM_GP-1:0][31:0] evtSel,
  input  logic [4*NUM_FIX-1:0] fixCtrl,
  input  logic [REG_W-1:0] globalEn,
  output logic [NUM_GP+NUM_FIX-1:0][CNT_W-1:0] counters,
  output logic [NUM_GP+NUM_FIX-1:0] ovfVec
);
  localparam int NUM_CNT = NUM_GP + NUM_FIX;
  localparam int SEL_IDX_W = (NUM_EVT > 1) ? $clog2(NUM_EVT) : 1;
  localparam int CMP_W = (INC_W > 8) ? INC_W : 8;

  logic [NUM_CNT-1:0] cntActive;
  logic [NUM_CNT-1:0][INC_W-1:0] cntAmount;
  logic [NUM_GP-1:0] condNow;
  logic [NUM_GP-1:0] prevCond;
  logic unusedBits;

  assign unusedBits = ^{strobe, evtSel, fixCtrl, globalEn};

  // general counters: event pick, filters, threshold modes
  for (genvar g = 0; g < NUM_GP; g++) begin : gGp
    logic [SEL_IDX_W-1:0] evIdx;
    logic [INC_W-1:0] rawCount;
    logic [7:0] thresh;
    logic privOk;

    assign evIdx = evtSel[g][SEL_IDX_W-1:0];
    assign rawCount = evtCount[evIdx];
    assign thresh = evtSel[g][SEL_THR_LSB +: 8];
    assign privOk = privUser ? evtSel[g][SEL_USR] : evtSel[g][SEL_OS];
    assign condNow[g] = (CMP_W'(rawCount) >= CMP_W'(thresh)) ^ evtSel[g][SEL_INV];
    assign cntActive[g] = evtSel[g][SEL_EN] & globalEn[g] & privOk;

    always_comb begin
      if (thresh == 8'd0) begin
        cntAmount[g] = rawCount;
      end else if (evtSel[g][SEL_EDGE]) begin
        cntAmount[g] = INC_W'(condNow[g] & ~prevCond[g]);
      end else begin
        cntAmount[g] = INC_W'(condNow[g]);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      prevCond <= '0;
    end else begin
      prevCond <= condNow;
    end
  end

  // fixed counters: dedicated lane, 4-bit field filter
  for (genvar f = 0; f < NUM_FIX; f++) begin : gFix
    logic [3:0] field;
    logic privOk;

    assign field = fixCtrl[4*f +: 4];
    assign privOk = privUser ? field[FIX_USR] : field[FIX_OS];
    assign cntActive[NUM_GP+f] = globalEn[GLOBAL_FIX_BASE+f] & privOk;
    assign cntAmount[NUM_GP+f] = fixCount[f];
  end

  // counter registers with write-over-increment priority
  for (genvar c = 0; c < NUM_CNT; c++) begin : gCnt
    logic [CNT_W:0] sum;

    assign sum = {1'b0, counters[c]} + (CNT_W+1)'(cntAmount[c]);
    assign ovfVec[c] = cntActive[c] & ~strobe.cntWr[c] & sum[CNT_W];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        counters[c] <= '0;
      end else if (strobe.cntWr[c]) begin
        counters[c] <= strobe.wrData[CNT_W-1:0];
      end else if (cntActive[c]) begin
        counters[c] <= sum[CNT_W-1:0];
      end
    end
  end
endmodule

// File: rtl/ecb_ctrl.sv
module ecb_ctrl
  import ecb_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FIX = 3,
  parameter int CNT_W = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0] regWrData,
  input  logic [NUM_GP+NUM_FIX-1:0][CNT_W-1:0] counters,
  input  logic [NUM_GP+NUM_FIX-1:0] ovfVec,
  output ecbStrobe_t strobe,
  output logic [NUM_GP-1:0][31:0] evtSel,
  output logic [4*NUM_FIX-1:0] fixCtrl,
  output logic [REG_W-1:0] globalEn,
  output logic [REG_W-1:0] statusReg,
  output logic [REG_W-1:0] regRdData,
  output logic irq
);
  localparam int NUM_CNT = NUM_GP + NUM_FIX;

  function automatic logic [REG_W-1:0] implMask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_GP; i++) m[i] = 1'b1;
    for (int i = 0; i < NUM_FIX; i++) m[GLOBAL_FIX_BASE+i] = 1'b1;
    return m;
  endfunction

  localparam logic [REG_W-1:0] IMPL_MASK = implMask();

  logic [REG_W-1:0] ovfPos;
  logic [REG_W-1:0] intMask;
  logic [REG_W-1:0] clrMask;
  logic wrSel, wrFix, wrGen, wrClr;

  assign wrFix = regWrEn && (regAddr == ADDR_FIXCTL);
  assign wrGen = regWrEn && (regAddr == ADDR_GEN);
  assign wrClr = regWrEn && (regAddr == ADDR_CLR);
  assign wrSel = regWrEn && (regAddr >= ADDR_SEL_BASE)
                 && (regAddr < ADDR_SEL_BASE + ADDR_W'(NUM_GP));
  assign clrMask = wrClr ? regWrData : '0;

  // strobes toward the datapath
  always_comb begin
    strobe.cntWr = '0;
    strobe.wrData = regWrData;
    for (int c = 0; c < NUM_CNT; c++) begin
      strobe.cntWr[c] = regWrEn && (regAddr == ADDR_W'(c));
    end
  end

  // map counter index to global bit position
  always_comb begin
    ovfPos = '0;
    intMask = '0;
    for (int g = 0; g < NUM_GP; g++) begin
      ovfPos[g] = ovfVec[g];
      intMask[g] = evtSel[g][SEL_INT];
    end
    for (int f = 0; f < NUM_FIX; f++) begin
      ovfPos[GLOBAL_FIX_BASE+f] = ovfVec[NUM_GP+f];
      intMask[GLOBAL_FIX_BASE+f] = fixCtrl[4*f+FIX_INT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      evtSel <= '0;
      fixCtrl <= '0;
      globalEn <= '0;
      statusReg <= '0;
    end else begin
      for (int g = 0; g < NUM_GP; g++) begin
        if (wrSel && (regAddr == ADDR_SEL_BASE + ADDR_W'(g))) begin
          evtSel[g] <= regWrData[31:0];
        end
      end
      if (wrFix) fixCtrl <= regWrData[4*NUM_FIX-1:0];
      if (wrGen) globalEn <= regWrData & IMPL_MASK;
      statusReg <= ((statusReg & ~clrMask) | ovfPos) & IMPL_MASK;
    end
  end

  assign irq = |(statusReg & intMask);

  // combinational read mux
  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NUM_CNT; c++) begin
      if (regAddr == ADDR_W'(c)) regRdData = REG_W'(counters[c]);
    end
    for (int g = 0; g < NUM_GP; g++) begin
      if (regAddr == ADDR_SEL_BASE + ADDR_W'(g)) regRdData = REG_W'(evtSel[g]);
    end
    if (regAddr == ADDR_FIXCTL) regRdData = REG_W'(fixCtrl);
    if (regAddr == ADDR_GEN) regRdData = globalEn;
    if (regAddr == ADDR_STAT) regRdData = statusReg;
  end
endmodule

// File: rtl/evt_counter_bank.sv
module evt_counter_bank
  import ecb_pkg::*;
#(
  parameter int NUM_GP = 4,
  parameter int NUM_FIX = 3,
  parameter int NUM_EVT = 8,
  parameter int INC_W = 4,
  parameter int CNT_W = 48
) (
  input  logic clk,
  input  logic rstN,
  input  logic privUser,
  input  logic [NUM_EVT-1:0][INC_W-1:0] evtCount,
  input  logic [NUM_FIX-1:0][INC_W-1:0] fixCount,
  input  logic regWrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  output logic irq
);
  localparam int NUM_CNT = NUM_GP + NUM_FIX;

  ecbStrobe_t strobe;
  logic [NUM_GP-1:0][31:0] evtSel;
  logic [4*NUM_FIX-1:0] fixCtrl;
  logic [REG_W-1:0] globalEn;
  logic [REG_W-1:0] statusReg;
  logic [NUM_CNT-1:0][CNT_W-1:0] counters;
  logic [NUM_CNT-1:0] ovfVec;

  ecb_ctrl #(.NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .CNT_W(CNT_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .counters(counters), .ovfVec(ovfVec),
    .strobe(strobe), .evtSel(evtSel), .fixCtrl(fixCtrl), .globalEn(globalEn),
    .statusReg(statusReg), .regRdData(regRdData), .irq(irq)
  );

  ecb_datapath #(
    .NUM_GP(NUM_GP), .NUM_FIX(NUM_FIX), .NUM_EVT(NUM_EVT),
    .INC_W(INC_W), .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .privUser(privUser),
    .evtCount(evtCount), .fixCount(fixCount), .evtSel(evtSel),
    .fixCtrl(fixCtrl), .globalEn(globalEn), .counters(counters), .ovfVec(ovfVec)
  );
endmodule

// File: rtl/ecb_checker.sv
module ecb_checker
  import ecb_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int NUM_CNT = 7
) (
  input logic clk,
  input logic rstN,
  input logic regWrEn,
  input logic [ADDR_W-1:0] regAddr,
  input logic [REG_W-1:0] regWrData,
  input logic [REG_W-1:0] regRdData,
  input logic irq,
  input logic [NUM_CNT-1:0] ovfVec,
  input logic [REG_W-1:0] statusReg,
  input logic [REG_W-1:0] globalEn,
  input logic [CNT_W-1:0] cnt0
);
  logic clrWr;
  logic cnt0Wr;
  assign clrWr = regWrEn && (regAddr == ADDR_CLR);
  assign cnt0Wr = regWrEn && (regAddr == '0);

  assert_hold_when_gated_R3: assert property (@(posedge clk) disable iff (!rstN)
    (!globalEn[0] && !cnt0Wr) |=> (cnt0 == $past(cnt0)));

  assert_ovf_sets_status_R7: assert property (@(posedge clk) disable iff (!rstN)
    ovfVec[0] |=> statusReg[0]);

  assert_status_sticky_R8: assert property (@(posedge clk) disable iff (!rstN)
    !clrWr |=> (($past(statusReg) & ~statusReg) == '0));

  assert_clear_drops_irq_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrWr && (&regWrData) && (ovfVec == '0)) |=> !irq);

  assert_write_takes_R10: assert property (@(posedge clk) disable iff (!rstN)
    cnt0Wr |=> (cnt0 == $past(regWrData[CNT_W-1:0])));

  assert_clear_reads_zero_R11: assert property (@(posedge clk) disable iff (!rstN)
    (regAddr == ADDR_CLR) |-> (regRdData == '0));
endmodule

bind evt_counter_bank ecb_checker #(.CNT_W(CNT_W), .NUM_CNT(NUM_CNT)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .regRdData(regRdData), .irq(irq), .ovfVec(ovfVec),
  .statusReg(statusReg), .globalEn(globalEn), .cnt0(counters[0])
);

// File: tb/tb_evt_counter_bank.sv
module tb_evt_counter_bank;
  localparam int NG = 4;
  localparam int NF = 3;
  localparam int NE = 8;
  localparam int IW = 4;
  localparam int CW = 48;
  localparam int NC = NG + NF;
  localparam logic [63:0] GEN_ALL = 64'h0000_0007_0000_000F;
  localparam logic [CW-1:0] CMAX = '1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic privUser = 1'b1;
  logic [NE-1:0][IW-1:0] evtCount = '0;
  logic [NF-1:0][IW-1:0] fixCount = '0;
  logic regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [63:0] regWrData = '0;
  logic [63:0] regRdData;
  logic irq;

  int checks = 0;
  int fails = 0;

  // bench model state
  logic [CW-1:0] mCnt [NC];
  logic [31:0] mSel [NG];
  logic [11:0] mFix;
  logic [63:0] mGen;
  logic [63:0] mStat;
  logic mPrev [NG];

  always #10 clk = ~clk;

  evt_counter_bank dut (
    .clk(clk), .rstN(rstN), .privUser(privUser), .evtCount(evtCount),
    .fixCount(fixCount), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irq(irq)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] modelRead(logic [4:0] a);
    if (a < 5'(NC)) return 64'(mCnt[a]);
    if (a >= 5'd16 && a < 5'd20) return 64'(mSel[a-5'd16]);
    if (a == 5'd28) return 64'(mFix);
    if (a == 5'd29) return mGen;
    if (a == 5'd30) return mStat;
    return '0;
  endfunction

  function automatic logic modelIrq();
    logic r;
    r = 1'b0;
    for (int g = 0; g < NG; g++) r |= mStat[g] & mSel[g][20];
    for (int f = 0; f < NF; f++) r |= mStat[32+f] & mFix[4*f+3];
    return r;
  endfunction

  function automatic string tagFor(logic [4:0] a);
    if (a < 5'(NG)) return "R2";
    if (a < 5'(NC)) return "R4";
    if (a == 5'd30) return "R8";
    return "R11";
  endfunction

  task automatic modelReset();
    for (int c = 0; c < NC; c++) mCnt[c] = '0;
    for (int g = 0; g < NG; g++) begin mSel[g] = '0; mPrev[g] = 1'b0; end
    mFix = '0; mGen = '0; mStat = '0;
  endtask

  task automatic modelStep();
    logic [63:0] nStat;
    logic nPrev [NG];
    nStat = mStat;
    if (regWrEn && regAddr == 5'd31) nStat = nStat & ~regWrData;
    for (int c = 0; c < NC; c++) begin
      logic act;
      logic [IW-1:0] amt;
      logic [CW:0] s;
      int pos;
      if (c < NG) begin
        logic [31:0] sl;
        logic [IW-1:0] raw;
        logic cond;
        sl = mSel[c];
        raw = evtCount[sl[2:0]];
        cond = ({4'b0, raw} >= sl[31:24]) ^ sl[23];
        nPrev[c] = cond;
        if (sl[31:24] == 8'd0) amt = raw;
        else if (sl[18]) amt = IW'(cond && !mPrev[c]);
        else amt = IW'(cond);
        act = sl[22] && mGen[c] && (privUser ? sl[16] : sl[17]);
        pos = c;
      end else begin
        logic [3:0] fld;
        fld = mFix[4*(c-NG) +: 4];
        act = mGen[32+c-NG] && (privUser ? fld[1] : fld[0]);
        amt = fixCount[c-NG];
        pos = 32 + c - NG;
      end
      if (regWrEn && regAddr == 5'(c)) begin
        mCnt[c] = regWrData[CW-1:0];
      end else if (act) begin
        s = {1'b0, mCnt[c]} + (CW+1)'(amt);
        mCnt[c] = s[CW-1:0];
        if (s[CW]) nStat[pos] = 1'b1;
      end
    end
    if (regWrEn) begin
      if (regAddr >= 5'd16 && regAddr < 5'd20) mSel[regAddr-5'd16] = regWrData[31:0];
      if (regAddr == 5'd28) mFix = regWrData[11:0];
      if (regAddr == 5'd29) mGen = regWrData & GEN_ALL;
    end
    mStat = nStat;
    for (int g = 0; g < NG; g++) mPrev[g] = nPrev[g];
  endtask

  // one cycle: inputs already driven at the falling edge
  task automatic tick();
    #1;
    chk(tagFor(regAddr), regRdData, modelRead(regAddr));
    chk("R9", 64'(irq), 64'(modelIrq()));
    modelStep();
    @(negedge clk);
  endtask

  task automatic zeroEv();
    evtCount = '0;
    fixCount = '0;
  endtask

  task automatic wr(logic [4:0] a, logic [63:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0;
  endtask

  task automatic expectRead(logic [4:0] a, logic [63:0] exp, string tag);
    zeroEv();
    regWrEn = 1'b0; regAddr = a;
    #1;
    chk(tag, regRdData, exp);
    tick();
  endtask

  task automatic runLane(int lane, logic [IW-1:0] v);
    evtCount = '0;
    evtCount[lane] = v;
    tick();
  endtask

  initial begin
    #(20 * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    modelReset();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int a = 0; a < 32; a++) begin
      regAddr = 5'(a);
      #1;
      chk("R1", regRdData, 64'h0);
    end
    chk("R1", 64'(irq), 64'h0);
    @(negedge clk);

    // R2: raw counting of lane 3
    zeroEv();
    wr(5'd29, GEN_ALL);
    wr(5'd16, 64'h0043_0003);
    for (int i = 0; i < 4; i++) begin
      evtCount = {NE{4'd7}};
      evtCount[3] = 4'd5;
      tick();
    end
    expectRead(5'd0, 64'd20, "R2");
    // R2: privilege filter blocks user mode
    wr(5'd16, 64'h0042_0003);
    for (int i = 0; i < 3; i++) runLane(3, 4'd5);
    expectRead(5'd0, 64'd20, "R2");
    // R3: global bit clear holds the counter
    wr(5'd16, 64'h0043_0003);
    wr(5'd29, GEN_ALL & ~64'h1);
    for (int i = 0; i < 3; i++) runLane(3, 4'd9);
    expectRead(5'd0, 64'd20, "R3");
    wr(5'd29, GEN_ALL);

    // R5: threshold 3, then inverted
    wr(5'd16, 64'h0343_0003);
    wr(5'd0, 64'd0);
    runLane(3, 4'd2); runLane(3, 4'd3); runLane(3, 4'd5); runLane(3, 4'd1);
    expectRead(5'd0, 64'd2, "R5");
    wr(5'd16, 64'h03C3_0003);
    wr(5'd0, 64'd0);
    runLane(3, 4'd2); runLane(3, 4'd3); runLane(3, 4'd5); runLane(3, 4'd1);
    expectRead(5'd0, 64'd2, "R5");

    // R6: edge counting
    wr(5'd16, 64'h0347_0003);
    wr(5'd0, 64'd0);
    runLane(3, 4'd5); runLane(3, 4'd5); runLane(3, 4'd0);
    runLane(3, 4'd5); runLane(3, 4'd5);
    expectRead(5'd0, 64'd2, "R6");

    // R4: fixed counter 1 admits supervisor mode only
    wr(5'd28, 64'h010);
    privUser = 1'b1;
    for (int i = 0; i < 3; i++) begin fixCount = '0; fixCount[1] = 4'd3; tick(); end
    expectRead(5'd5, 64'd0, "R4");
    privUser = 1'b0;
    for (int i = 0; i < 3; i++) begin fixCount = '0; fixCount[1] = 4'd3; tick(); end
    expectRead(5'd5, 64'd9, "R4");
    privUser = 1'b1;

    // R7, R9, R10: preload minus three, interrupt enabled
    wr(5'd17, 64'h0053_0002);
    wr(5'd1, 64'(CMAX - 48'd2));
    for (int i = 0; i < 3; i++) runLane(2, 4'd1);
    expectRead(5'd1, 64'd0, "R7");
    regAddr = 5'd30;
    #1;
    chk("R7", regRdData, 64'h2);
    chk("R9", 64'(irq), 64'h1);
    tick();
    // R8: status address ignores writes
    wr(5'd30, '1);
    expectRead(5'd30, 64'h2, "R8");
    wr(5'd31, 64'h2);
    expectRead(5'd30, 64'h0, "R8");
    chk("R9", 64'(irq), 64'h0);

    // R9: overflow without interrupt enable
    wr(5'd18, 64'h0043_0002);
    wr(5'd2, 64'(CMAX));
    runLane(2, 4'd1);
    expectRead(5'd30, 64'h4, "R7");
    chk("R9", 64'(irq), 64'h0);
    wr(5'd31, '1);

    // R10: write wins over same-cycle increment, then continues
    evtCount = '0; evtCount[2] = 4'd1;
    wr(5'd1, 64'd50);
    expectRead(5'd1, 64'd50, "R10");
    runLane(2, 4'd1);
    expectRead(5'd1, 64'd51, "R10");
    // R10: write of all ones during an active cycle does not overflow
    evtCount = '0; evtCount[2] = 4'd1;
    wr(5'd1, 64'(CMAX));
    expectRead(5'd30, 64'h0, "R10");

    // R11: register map readback
    expectRead(5'd17, 64'h0053_0002, "R11");
    expectRead(5'd28, 64'h010, "R11");
    expectRead(5'd29, GEN_ALL, "R11");
    expectRead(5'd31, 64'h0, "R11");
    expectRead(5'd8, 64'h0, "R11");

    // random phase against the model
    for (int i = 0; i < 4000; i++) begin
      for (int e = 0; e < NE; e++) evtCount[e] = IW'($urandom);
      for (int f = 0; f < NF; f++) fixCount[f] = IW'($urandom);
      privUser = 1'($urandom);
      regAddr = 5'($urandom);
      regWrEn = ($urandom % 5) == 0;
      regWrData = {$urandom, $urandom};
      if (regWrEn) begin
        if (regAddr < 5'(NC) && ($urandom % 2) == 0)
          regWrData = 64'(CMAX - 48'($urandom % 20));
        if (regAddr >= 5'd16 && regAddr < 5'd20) begin
          regWrData[22] = ($urandom % 4) != 0;
          if ($urandom % 2) regWrData[31:24] = 8'($urandom % 10);
          else regWrData[31:24] = 8'd0;
        end
      end
      tick();
    end
    regWrEn = 1'b0;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule